// File: doc/BRIEF.md
# Periodic Wakeup Interval Timer

This block is a low-power periodic wakeup timer for a real-time-clock domain. It counts selected ticks down from a programmable reload value. Each time the count passes zero it sets a sticky wakeup flag and starts the next interval from the reload value, so the flag period is the effective reload value plus one tick.

A 3-bit selector picks the tick source. It can use one of four divisions of the RTC clock, taken from a free-running prefix divider as single-cycle tick enables, or an external once-per-second strobe. Its top codes also stretch the interval by 2^16.

Software works the block through a small register port: a control word with the enable bit, the reload value, the selector, and a status word holding the write-allowed flag and the wakeup flag. The reload value and the selector are guarded against change while the timer runs. They can be written only while the timer is disabled and the write-allowed flag is set. That flag drops as soon as the timer is enabled and comes back two clock cycles after it is disabled.

Top module: `wkup_timer`

## Requirements
- R1: After reset the control word (address 0) reads 0, reload (address 1) reads 0, selector (address 2) reads 0, and status (address 3) reads 0x0001. Status bit 0 is write-allowed and bit 1 is the wakeup flag.
- R2: With selector codes 000, 001, 010 and 011 the timer ticks once every 16, 8, 4 and 2 clock cycles respectively. With reload N, consecutive wakeup flag sets are (N+1) times that many cycles apart.
- R3: With selector codes 100 and 101 the timer advances only on cycles where the second strobe input is high. The wakeup flag sets on the (N+1)th strobe after enabling, and the prefix divider has no effect.
- R4: With selector codes 110 and 111 the interval is N + 0x10000 plus one strobes. For N = 0, 0x10000 strobes leave the flag clear and the 0x10001st strobe sets it.
- R5: Writes to reload and selector are ignored while the enable bit is 1 or the write-allowed flag is 0.
- R6: Writing 1 to control bit 0 while disabled enables the timer, and write-allowed reads 0 from the next cycle. Writing 0 disables it, and write-allowed reads 1 two cycles after the disabling write edge, and 0 before that.
- R7: The wakeup flag is sticky. A status write with bit 1 = 0 clears it, and a status write with bit 1 = 1 leaves it unchanged.
- R8: While disabled the counter holds, so the wakeup flag never sets.
- R9: On reaching zero at a tick the counter reloads the effective reload value, which keeps the period constant from one interval to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_strobe_i | input | 1 | Once-per-second tick enable pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 16 | Register read data, combinational |

## Verification
The hardest state to reach is the far end of the extended interval, where the counter must pass through 0x10000 before expiring. The bench holds the second strobe high for exactly 0x10000 cycles, confirms the flag is still clear, and then gives one more strobe. The lock window right after disabling is the other narrow spot. The bench checks write-allowed on each of the two settle cycles, and it aims a reload write into that window to show the write is dropped.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
    localparam int RELOAD_W = 16;
    localparam int CNT_W    = RELOAD_W + 1;
    localparam int PRE_W    = 4;
    localparam int ADDR_W   = 2;
    localparam int DATA_W   = 16;
    localparam int SEL_W    = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
    localparam logic [ADDR_W-1:0] A_SEL    = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT   = 2'd3;

    typedef struct packed {
        logic       use_sec;
        logic       extend;
        logic [1:0] div_code;
    } sel_dec_t;

    function automatic sel_dec_t decode_sel(input logic [SEL_W-1:0] s);
        sel_dec_t d;
        d.use_sec  = s[2];
        d.extend   = s[2] & s[1];
        d.div_code = s[1:0];
        return d;
    endfunction

    function automatic logic [CNT_W-1:0] eff_reload(input logic [RELOAD_W-1:0] r,
                                                    input sel_dec_t d);
        return {d.extend, r};
    endfunction
endpackage

// File: rtl/wkup_prescaler.sv
module wkup_prescaler
    import wkup_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       div_code,
    output logic             div_tick
);
    logic [PRE_W-1:0] cnt;
    logic [PRE_W:1]   tick_k;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    for (genvar k = 1; k <= PRE_W; k++) begin : g_tick
        assign tick_k[k] = &cnt[k-1:0];
    end

    always_comb begin
        div_tick = tick_k[PRE_W - int'(div_code)];
    end

    // R2: a slower tick always coincides with every faster one
    p_nested_ticks_r2: assert property (@(posedge clk) disable iff (rst)
        tick_k[PRE_W] |-> (&tick_k));
endmodule

// File: rtl/wkup_regs.sv
module wkup_regs
    import wkup_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 set_flag,
    output logic                 en,
    output logic [RELOAD_W-1:0]  reload,
    output logic [SEL_W-1:0]     sel,
    output logic                 wr_ok,
    output logic                 flag,
    output logic                 start
);
    logic settle;
    logic cfg_open;
    logic wr_ctrl, wr_stat, stop;

    assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
    assign wr_stat  = wr_en && (wr_addr == A_STAT);
    assign start    = wr_ctrl && wr_data[0] && !en;
    assign stop     = wr_ctrl && !wr_data[0];
    assign cfg_open = !en && wr_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            en     <= 1'b0;
            settle <= 1'b1;
            wr_ok  <= 1'b1;
            reload <= '0;
            sel    <= '0;
            flag   <= 1'b0;
        end else begin
            if (start)     en <= 1'b1;
            else if (stop) en <= 1'b0;

            if (start) begin
                settle <= 1'b0;
                wr_ok  <= 1'b0;
            end else begin
                settle <= !en;
                wr_ok  <= settle && !en;
            end

            if (wr_en && cfg_open && wr_addr == A_RELOAD) reload <= wr_data[RELOAD_W-1:0];
            if (wr_en && cfg_open && wr_addr == A_SEL)    sel    <= wr_data[SEL_W-1:0];

            if (set_flag)                   flag <= 1'b1;
            else if (wr_stat && !wr_data[1]) flag <= 1'b0;
        end
    end

    p_cfg_locked_r5: assert property (@(posedge clk) disable iff (rst)
        (en || !wr_ok) |=> ($stable(reload) && $stable(sel)));
    p_wrok_drop_r6: assert property (@(posedge clk) disable iff (rst)
        start |=> (en && !wr_ok));
    p_wrok_only_idle_r6: assert property (@(posedge clk) disable iff (rst)
        wr_ok |-> !en);
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flag && !(wr_stat && !wr_data[1])) |=> flag);
endmodule

// File: rtl/wkup_counter.sv
module wkup_counter
    import wkup_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             start,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload_eff,
    output logic             expire
);
    logic [CNT_W-1:0] count;

    assign expire = en && !start && tick && (count == '0);

    always_ff @(posedge clk) begin
        if (rst)                 count <= '0;
        else if (start)          count <= reload_eff;
        else if (en && tick) begin
            if (count == '0)     count <= reload_eff;
            else                 count <= count - 1'b1;
        end
    end

    p_hold_when_off_r8: assert property (@(posedge clk) disable iff (rst)
        (!en && !start) |=> $stable(count));
    p_reload_on_expire_r9: assert property (@(posedge clk) disable iff (rst)
        expire |=> (count == $past(reload_eff)));
endmodule

// File: rtl/wkup_timer.sv
module wkup_timer
    import wkup_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_strobe_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [15:0]       wr_data_i,
    input  logic [1:0]        rd_addr_i,
    output logic [15:0]       rd_data_o
);
    logic                en, wr_ok, flag, start, expire, div_tick, tick;
    logic [RELOAD_W-1:0] reload;
    logic [SEL_W-1:0]    sel;
    sel_dec_t            dec;
    logic [CNT_W-1:0]    reload_eff;

    assign dec        = decode_sel(sel);
    assign reload_eff = eff_reload(reload, dec);
    assign tick       = dec.use_sec ? sec_strobe_i : div_tick;

    wkup_prescaler u_pre (
        .clk(clk), .rst(rst), .div_code(dec.div_code), .div_tick(div_tick)
    );

    wkup_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
        .wr_data(wr_data_i), .set_flag(expire), .en(en), .reload(reload),
        .sel(sel), .wr_ok(wr_ok), .flag(flag), .start(start)
    );

    wkup_counter u_cnt (
        .clk(clk), .rst(rst), .en(en), .start(start), .tick(tick),
        .reload_eff(reload_eff), .expire(expire)
    );

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            A_CTRL:   rd_data_o[0]          = en;
            A_RELOAD: rd_data_o             = reload;
            A_SEL:    rd_data_o[SEL_W-1:0]  = sel;
            default:  rd_data_o[1:0]        = {flag, wr_ok};
        endcase
    end

    p_flag_needs_run_r8: assert property (@(posedge clk) disable iff (rst)
        (!en && !u_regs.flag) |=> !u_regs.flag);
endmodule

// File: tb/wkup_timer_tb.sv
module wkup_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int n_run = 0, n_fail = 0;
    int cyc = 0;

    typedef struct {
        logic [1:0]  addr;
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wkup_timer u_dut (
        .clk(clk), .rst(rst), .sec_strobe_i(sec), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data)
    );

    // monitor: pops expected reads and compares away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_run++;
            if (rd_data !== it.exp) begin
                n_fail++;
                $display("FAIL %s addr=%0d actual=0x%04h expected=0x%04h",
                         it.tag, it.addr, rd_data, it.exp);
            end
        end
    end

    task automatic expect_rd(input logic [1:0] a, input logic [15:0] e, input string tag);
        item_t it;
        rd_addr = a;
        it.addr = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic expect_val(input int got, input int e, input string tag);
        n_run++;
        if (got != e) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, e);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_flag(output int t);
        rd_addr = 2'd3;
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk); #1;
            if (rd_data[1]) break;
        end
        t = cyc;
    endtask

    task automatic strobes(input int n);
        @(posedge clk); #1;
        sec = 1'b1;
        repeat (n) @(posedge clk);
        #1 sec = 1'b0;
    endtask

    task automatic measure_period(input logic [2:0] s, input int div);
        int t1, t2;
        wr(2'd0, 16'h0000);
        repeat (3) @(posedge clk);
        wr(2'd1, 16'd3);
        wr(2'd2, {13'd0, s});
        wr(2'd3, 16'h0000);
        wr(2'd0, 16'h0001);
        wait_flag(t1);
        wr(2'd3, 16'h0000);
        wait_flag(t2);
        expect_val(t2 - t1, 4 * div, $sformatf("R2 R9 period sel=%0d", s));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;

        // R1 reset state
        expect_rd(2'd0, 16'h0000, "R1 ctrl");
        expect_rd(2'd1, 16'h0000, "R1 reload");
        expect_rd(2'd2, 16'h0000, "R1 sel");
        expect_rd(2'd3, 16'h0001, "R1 status");

        // R2 / R9 divided tick periods with reload 3
        measure_period(3'b000, 16);
        measure_period(3'b001, 8);
        measure_period(3'b010, 4);
        measure_period(3'b011, 2);

        // R6 enable/disable handshake, R5 lock
        wr(2'd0, 16'h0000);
        repeat (3) @(posedge clk);
        wr(2'd1, 16'd7);
        expect_rd(2'd1, 16'd7, "R5 reload accepted when idle");
        wr(2'd0, 16'h0001);
        expect_rd(2'd3, 16'h0000 | (rd_data & 16'h0002), "R6 wr_ok low after enable");
        wr(2'd1, 16'd9);
        wr(2'd2, 16'd5);
        expect_rd(2'd1, 16'd7, "R5 reload locked while enabled");
        expect_rd(2'd2, 16'd3, "R5 sel locked while enabled");
        wr(2'd3, 16'h0000);
        wr(2'd0, 16'h0000);
        expect_rd(2'd3, 16'h0000, "R6 wr_ok low on disable edge+0");
        @(posedge clk); #1;
        expect_rd(2'd3, 16'h0000, "R6 wr_ok low on disable edge+1");
        @(posedge clk); #1;
        expect_rd(2'd3, 16'h0001, "R6 wr_ok high on disable edge+2");

        // R5 write into the settle window is dropped
        wr(2'd0, 16'h0001);
        wr(2'd0, 16'h0000);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'd11;
        @(posedge clk); #1;
        wr_en = 1'b0;
        repeat (3) @(posedge clk); #1;
        expect_rd(2'd1, 16'd7, "R5 reload dropped during settle");

        // R3 second strobe source, reload 2
        wr(2'd3, 16'h0000);
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd4);
        wr(2'd0, 16'h0001);
        repeat (100) @(posedge clk); #1;
        expect_rd(2'd3, 16'h0000, "R3 no tick without strobe");
        strobes(2);
        expect_rd(2'd3, 16'h0000, "R3 clear after 2 strobes");
        strobes(1);
        expect_rd(2'd3, 16'h0002, "R3 set on 3rd strobe");

        // R7 sticky flag, R8 hold while disabled
        wr(2'd0, 16'h0000);
        strobes(10);
        wr(2'd3, 16'h0002);
        expect_rd(2'd3, 16'h0003, "R7 write 1 keeps flag");
        wr(2'd3, 16'h0000);
        expect_rd(2'd3, 16'h0001, "R7 write 0 clears flag");
        strobes(10);
        expect_rd(2'd3, 16'h0001, "R8 no flag while disabled");

        // R3 code 101 also uses strobe, reload 0 -> every strobe
        wr(2'd2, 16'd5);
        wr(2'd1, 16'd0);
        wr(2'd0, 16'h0001);
        strobes(1);
        expect_rd(2'd3, 16'h0002, "R3 sel 101 reload 0 one strobe");
        wr(2'd0, 16'h0000);
        repeat (3) @(posedge clk);

        // R4 extended interval, sel 111, reload 0
        wr(2'd3, 16'h0000);
        wr(2'd2, 16'd7);
        wr(2'd0, 16'h0001);
        strobes(32'h10000);
        expect_rd(2'd3, 16'h0000, "R4 clear after 0x10000 strobes");
        strobes(1);
        expect_rd(2'd3, 16'h0002, "R4 set on 0x10001st strobe");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule